// File: doc/BRIEF.md
# I2C Slave with Byte-Level Clock Stretching

This block is an I2C target controller that sits behind a small processor-side register window. After a START it shifts in the first byte on the bus, compares its upper seven bits with a programmable own address and, on a match, acknowledges and latches the lowest bit as the transfer direction. The direction decides whether the following bytes are received into the data register or sent from it, with no software involvement in the switch.

Every completed byte raises an event flag, the address byte included. While the flag is pending the block pulls SCL low, so the bus master is stalled until software has read the received byte or supplied the next byte to send and then cleared the flag. An interrupt output follows the flag when interrupts are enabled. Both bus lines are open-drain: the block only ever drives low or releases, and the system clock is assumed to run several times faster than SCL.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset the control, address and data registers read 00h, neither bus line is pulled low and the interrupt output is 0.
- R2: Control register (offset 0) bit 7 enables acknowledge, bit 6 enables the block, bit 5 enables the interrupt; writing E0h reads back as E0h. The address register (offset 1) holds 7 bits and its bit 7 reads 0.
- R3: The block acknowledges (SDA low in the 9th clock) the first byte after a START only when its upper seven bits equal the own address; on a mismatch it neither acknowledges nor sets the flag, and it ignores further bytes until the next START.
- R4: The lowest bit of a matched address byte is kept in control bit 3 (1 means the master reads and the block transmits); that bit is read-only.
- R5: In receive direction each data byte is acknowledged and can be read from the data register (offset 2) once the flag is set.
- R6: In transmit direction the byte written to the data register is sent most significant bit first after the flag is cleared.
- R7: The flag (control bit 2) is set at the end of the acknowledge clock of every byte, including the address byte; writing 0 to bit 2 clears it, writing 1 leaves it unchanged.
- R8: While the flag is pending after an acknowledged byte, SCL is held low and SDA is released except for the next transmit bit; SCL is released within two clocks after the clearing write.
- R9: The interrupt output equals the flag gated by the interrupt-enable bit.
- R10: With acknowledge disabled the block drives no ACK, on the address or on data, yet the flag is still set.
- R11: A NACK from the master after a transmitted byte sets the flag without stretching; the block then releases SDA and ignores the bus until STOP or START.
- R12: A repeated START restarts the address phase so the direction can change; with the block disabled it does not respond to the bus at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 control/status, 1 own address, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected offset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Byte-event interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 7-bit own address and two synchronizer stages. At that size every one of the 128 possible addresses is offered against one programmed address, and all 256 byte values are pushed through both the receive and the transmit path with a stretch and release around each byte. The enable bits, the write-one-has-no-effect rule on the flag, master NACK and a repeated START with a change of direction are then exercised on the same configuration.

// File: rtl/i2c_slv_pkg.sv
// Shared constants and the link state type for the I2C stretching slave.
// Assumes an 8-bit control register layout; bit positions are fixed here.
package i2c_slv_pkg;
    localparam logic [1:0] OFS_CTL = 2'd0;
    localparam logic [1:0] OFS_ADR = 2'd1;
    localparam logic [1:0] OFS_DAT = 2'd2;

    localparam int CTL_ACKEN = 7;
    localparam int CTL_EN    = 6;
    localparam int CTL_IRQEN = 5;
    localparam int CTL_DIR   = 3;
    localparam int CTL_FLAG  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_HOLD,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
// Synchronizes SCL and SDA into the system clock and derives SCL edges and
// START/STOP events. Assumes the system clock is several times SCL.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic scl_s, scl_p, sda_s, sda_p;

    // Shift both lines through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        scl_p     = scl_pipe[STAGES];
        sda_s     = sda_pipe[STAGES-1];
        sda_p     = sda_pipe[STAGES];
        sda       = sda_s;
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_regs.sv
// Processor-side registers: control/status, own address and shared data.
// Assumes single-cycle writes; reads are combinational on the offset.
module i2c_regs
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              byte_done,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              dir,
    output logic              ack_en,
    output logic              mod_en,
    output logic              irq_en,
    output logic              flag,
    output logic [ADDR_W-1:0] own_addr,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq
);
    logic wr_ctl, wr_adr, wr_dat;
    logic [DATA_W-1:0] ctl_word;

    // Decode write strobes per register.
    always_comb begin
        wr_ctl = reg_wr && (reg_addr == OFS_CTL);
        wr_adr = reg_wr && (reg_addr == OFS_ADR);
        wr_dat = reg_wr && (reg_addr == OFS_DAT);
    end

    // Enable bits and own address, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en   <= 1'b0;
            mod_en   <= 1'b0;
            irq_en   <= 1'b0;
            own_addr <= '0;
        end else begin
            if (wr_ctl) begin
                ack_en <= reg_wdata[CTL_ACKEN];
                mod_en <= reg_wdata[CTL_EN];
                irq_en <= reg_wdata[CTL_IRQEN];
            end
            if (wr_adr) own_addr <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Byte-event flag: set by the link, cleared by writing 0; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (byte_done)                      flag <= 1'b1;
        else if (wr_ctl && !reg_wdata[CTL_FLAG]) flag <= 1'b0;
    end

    // Shared data register: received bytes overwrite software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_byte <= '0;
        else if (rx_load) tx_byte <= rx_byte;
        else if (wr_dat)  tx_byte <= reg_wdata;
    end

    // Assemble the control/status word and the read mux.
    always_comb begin
        ctl_word            = '0;
        ctl_word[CTL_ACKEN] = ack_en;
        ctl_word[CTL_EN]    = mod_en;
        ctl_word[CTL_IRQEN] = irq_en;
        ctl_word[CTL_DIR]   = dir;
        ctl_word[CTL_FLAG]  = flag;
        case (reg_addr)
            OFS_CTL: reg_rdata = ctl_word;
            OFS_ADR: reg_rdata = {1'b0, own_addr};
            OFS_DAT: reg_rdata = tx_byte;
            default: reg_rdata = '0;
        endcase
        irq = flag & irq_en;
    end
endmodule

// File: rtl/i2c_link_fsm.sv
// Byte-level protocol engine: address match, direction capture, shifting,
// ACK handling and the stretch state. Works on synchronized bus events.
module i2c_link_fsm
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              mod_en,
    input  logic              ack_en,
    input  logic              flag,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              byte_done,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              dir,
    output logic              scl_low,
    output logic              sda_low
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    link_state_t       st, st_d;
    logic [DATA_W-1:0] sh, sh_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic              dir_d, ackd, ackd_d, nack, nack_d;

    // Next-state logic for the link, with bus conditions taking priority.
    always_comb begin
        st_d = st; sh_d = sh; cnt_d = cnt; dir_d = dir;
        ackd_d = ackd; nack_d = nack;
        byte_done = 1'b0; rx_load = 1'b0;
        if (!mod_en) begin
            st_d = ST_IDLE; ackd_d = 1'b0;
        end else if (start_det) begin
            st_d = ST_ADDR; cnt_d = '0; ackd_d = 1'b0;
        end else if (stop_det) begin
            st_d = ST_IDLE; ackd_d = 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && cnt < FULL) begin
                        sh_d  = {sh[DATA_W-2:0], sda};
                        cnt_d = cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        if (st == ST_RX) begin
                            rx_load = 1'b1;
                            ackd_d  = ack_en;
                            st_d    = ST_RACK;
                        end else if (sh[DATA_W-1:1] == own_addr) begin
                            dir_d  = sh[0];
                            ackd_d = ack_en;
                            st_d   = ST_AACK;
                        end else begin
                            st_d = ST_SKIP;
                        end
                    end
                end
                ST_AACK, ST_RACK: begin
                    if (scl_fall) begin
                        ackd_d = 1'b0; byte_done = 1'b1; st_d = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!flag) begin
                        cnt_d = '0;
                        if (dir) begin sh_d = tx_byte; st_d = ST_TX; end
                        else     st_d = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        sh_d  = {sh[DATA_W-2:0], 1'b1};
                        cnt_d = cnt + 1'b1;
                        if (cnt == LAST) st_d = ST_TACK;
                    end
                end
                ST_TACK: begin
                    if (scl_rise) nack_d = sda;
                    if (scl_fall) begin
                        byte_done = 1'b1;
                        st_d = nack ? ST_SKIP : ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    // State registers of the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; sh <= '0; cnt <= '0;
            dir <= 1'b0; ackd <= 1'b0; nack <= 1'b0;
        end else begin
            st <= st_d; sh <= sh_d; cnt <= cnt_d;
            dir <= dir_d; ackd <= ackd_d; nack <= nack_d;
        end
    end

    // Open-drain drive: ACK, transmit bits, and SCL held during the stretch.
    always_comb begin
        rx_byte = sh;
        scl_low = (st == ST_HOLD);
        case (st)
            ST_AACK, ST_RACK: sda_low = ackd;
            ST_TX:            sda_low = ~sh[DATA_W-1];
            ST_HOLD:          sda_low = dir & ~tx_byte[DATA_W-1];
            default:          sda_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_stretch_slave.sv
// Top of the I2C stretching slave: bus synchronizer, register window and
// protocol engine. Assumes open-drain lines driven only low by this block.
module i2c_stretch_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              irq
);
    localparam int ADDR_W = DATA_W - 1;

    logic sda, scl_rise, scl_fall, start_det, stop_det;
    logic byte_done, rx_load, dir, ack_en, mod_en, irq_en, flag;
    logic [DATA_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda(sda), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .byte_done(byte_done), .rx_load(rx_load), .rx_byte(rx_byte),
        .dir(dir), .ack_en(ack_en), .mod_en(mod_en), .irq_en(irq_en),
        .flag(flag), .own_addr(own_addr), .tx_byte(tx_byte), .irq(irq)
    );

    i2c_link_fsm #(.DATA_W(DATA_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda(sda), .start_det(start_det), .stop_det(stop_det),
        .mod_en(mod_en), .ack_en(ack_en), .flag(flag), .own_addr(own_addr),
        .tx_byte(tx_byte), .byte_done(byte_done), .rx_load(rx_load),
        .rx_byte(rx_byte), .dir(dir), .scl_low(scl_drive_low),
        .sda_low(sda_drive_low)
    );
endmodule

// File: rtl/i2c_slave_chk.sv
// Property checker for the I2C stretching slave, attached through bind.
module i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_low,
    input logic sda_low,
    input logic irq,
    input logic flag,
    input logic byte_done,
    input logic mod_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!scl_low && !sda_low && !irq));

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(byte_done));

    // R8
    stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> flag);

    // R8
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low && !flag) |=> !scl_low);

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R12
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (!scl_low && !sda_low));
endmodule

bind i2c_stretch_slave i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_low(scl_drive_low),
    .sda_low(sda_drive_low), .irq(irq), .flag(flag),
    .byte_done(byte_done), .mod_en(mod_en)
);

// File: tb/sim_i2c_stretch_slave.sv
module sim_i2c_stretch_slave;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int WAIT_MAX   = 2000;
    localparam int WD_CYCLES  = 190000;
    localparam logic [6:0] OWN = 7'h5A;
    localparam logic [1:0] A_CTL = 2'd0, A_ADR = 2'd1, A_DAT = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic scl_drive_low, sda_drive_low, irq;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_line, sda_line;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    assign scl_line = m_scl & ~scl_drive_low;
    assign sda_line = m_sda & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stretch_slave u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_line),
        .sda_in(sda_line), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic scl_up();
        int n;
        n = 0;
        m_scl = 1'b1;
        while (!scl_line && n < WAIT_MAX) begin @(negedge clk); n++; end
        if (!scl_line) chk("R8 SCL never released", 0, 1);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; hold(P);
        scl_up(); hold(P/2);
        s = sda_line; hold(P/2);
        m_scl = 1'b0; hold(P);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(P);
        scl_up(); hold(P);
        m_sda = 1'b0; hold(P);
        m_scl = 1'b0; hold(P);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(P);
        scl_up(); hold(P);
        m_sda = 1'b1; hold(P);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(~give_ack, s);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        chk("watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        logic [7:0] r, got, v;
        logic ak;
        hold(5); rst_n = 1'b1; hold(2);

        // R1 reset state
        rd(A_CTL, r); chk("R1 ctrl reset", r, 8'h00);
        rd(A_ADR, r); chk("R1 addr reset", r, 8'h00);
        rd(A_DAT, r); chk("R1 data reset", r, 8'h00);
        chk("R1 no drive", {scl_drive_low, sda_drive_low, irq}, 0);

        // R2 register fields
        wr(A_ADR, {1'b1, OWN});
        rd(A_ADR, r); chk("R2 addr bit7 reads 0", r, {1'b0, OWN});
        wr(A_CTL, 8'hE0);
        rd(A_CTL, r); chk("R2 ctrl readback", r, 8'hE0);

        // R3 address sweep, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ak);
            chk("R3 ack on match only", ak, (7'(a) == OWN));
            rd(A_CTL, r);
            chk("R3 flag on match only", r[2], (7'(a) == OWN));
            if (7'(a) == OWN) begin
                chk("R4 dir write", r[3], 0);
                chk("R9 irq with flag", irq, 1);
                wr(A_CTL, 8'hE0);
            end else begin
                send_byte({OWN, 1'b0}, ak);
                chk("R3 ignored until START", ak, 0);
                rd(A_CTL, r); chk("R3 no flag when ignored", r[2], 0);
            end
            bus_stop();
        end

        // R5 R7 R8 receive sweep over all byte values
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R5 address ack", ak, 1);
        chk("R8 stretch after address", scl_drive_low, 1);
        // R7 writing 1 to flag and bit3 has no effect
        wr(A_CTL, 8'hEC);
        rd(A_CTL, r); chk("R7 write-one keeps flag, R4 dir read-only", r, 8'hE4);
        chk("R8 still held", scl_drive_low, 1);
        hold(30);
        chk("R8 held while pending", scl_drive_low, 1);
        chk("R8 SDA released in receive stretch", sda_drive_low, 0);
        wr(A_CTL, 8'hE0); hold(1);
        chk("R8 released after clear", scl_drive_low, 0);
        rd(A_CTL, r); chk("R7 flag cleared", r[2], 0);
        chk("R9 irq follows flag", irq, 0);
        for (int i = 0; i < 256; i++) begin
            v = 8'(i * 13 + 7);
            send_byte(v, ak);
            chk("R5 data ack", ak, 1);
            chk("R8 stretch per byte", scl_drive_low, 1);
            rd(A_CTL, r); chk("R7 flag per byte", r[2], 1);
            rd(A_DAT, r); chk("R5 received byte", r, v);
            wr(A_CTL, 8'hE0);
        end
        bus_stop();

        // R6 transmit sweep with master NACK at the end (R11)
        bus_start();
        send_byte({OWN, 1'b1}, ak);
        chk("R6 read address ack", ak, 1);
        rd(A_CTL, r); chk("R4 dir read", r[3], 1);
        v = 8'd11;
        wr(A_DAT, v); wr(A_CTL, 8'hE0);
        for (int i = 0; i < 256; i++) begin
            recv_byte(got, i != 255);
            chk("R6 transmitted byte", got, v);
            rd(A_CTL, r); chk("R7 flag after tx byte", r[2], 1);
            if (i != 255) begin
                chk("R8 stretch after tx byte", scl_drive_low, 1);
                v = 8'((i + 1) * 37 + 11);
                wr(A_DAT, v); wr(A_CTL, 8'hE0);
            end else begin
                chk("R11 no stretch after NACK", scl_drive_low, 0);
                chk("R11 SDA released after NACK", sda_drive_low, 0);
            end
        end
        wr(A_CTL, 8'hE0);
        recv_byte(got, 1'b0);
        chk("R11 bus ignored after NACK", got, 8'hFF);
        rd(A_CTL, r); chk("R11 no flag while ignoring", r[2], 0);
        bus_stop();

        // R12 repeated START switches direction
        bus_start();
        send_byte({OWN, 1'b0}, ak); wr(A_CTL, 8'hE0);
        send_byte(8'h33, ak);
        rd(A_DAT, r); chk("R5 byte before repeated START", r, 8'h33);
        wr(A_CTL, 8'hE0);
        bus_start();
        send_byte({OWN, 1'b1}, ak);
        chk("R12 ack after repeated START", ak, 1);
        rd(A_CTL, r); chk("R12 dir switched", r[3], 1);
        wr(A_DAT, 8'hC3); wr(A_CTL, 8'hE0);
        recv_byte(got, 1'b0);
        chk("R12 byte after repeated START", got, 8'hC3);
        wr(A_CTL, 8'hE0);
        bus_stop();

        // R10 acknowledge disabled
        wr(A_CTL, 8'h60);
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R10 no address ack", ak, 0);
        rd(A_CTL, r); chk("R10 flag still set", r[2], 1);
        wr(A_CTL, 8'h60);
        send_byte(8'h5C, ak);
        chk("R10 no data ack", ak, 0);
        rd(A_DAT, r); chk("R10 byte still received", r, 8'h5C);
        wr(A_CTL, 8'h60);
        bus_stop();

        // R9 interrupt disabled
        wr(A_CTL, 8'hC0);
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        rd(A_CTL, r); chk("R9 flag set", r[2], 1);
        chk("R9 irq masked", irq, 0);
        wr(A_CTL, 8'hC0);
        bus_stop();

        // R12 block disabled
        wr(A_CTL, 8'hA0);
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R12 disabled no ack", ak, 0);
        rd(A_CTL, r); chk("R12 disabled no flag", r[2], 0);
        chk("R12 disabled no stretch", scl_drive_low, 0);
        bus_stop();

        finish_sim();
    end
endmodule